// File: doc/BRIEF.md
# Dual-expiration watchdog timer

This block watches for a stalled processor. A counter runs freely from the moment reset is released. It counts every clock cycle and never stops. A parameter sets the timeout to 2^INTERVAL cycles. An expiry happens each time the low INTERVAL bits of the count are all ones and are about to wrap.

While the watchdog is enabled, expiries act in two stages:
- The first expiry raises a one-cycle interrupt and sets a warning bit.
- If software has not cleared that bit by the next expiry, the block drives its reset output for RST_HOLD cycles. It then records that a watchdog reset took place and falls back to the disabled state.

Clearing the warning bit does not restart the count, so the next expiry is always measured on the free-running count. When ENABLE_ONCE is set, an enabled watchdog ignores attempts to disable it. The only way out of the enabled state is its own reset sequence.

Software reaches the block through a small register port with plain control pins. A write takes effect at the clock edge where `reg_wr` is high. A read is combinational from `reg_addr`.
- Address 0 is the control/status word. Bit 0 is the enable, bit 1 is the warning bit (write one to clear) and bit 2 is the reset-happened flag (write one to clear).
- Address 4 returns the current timebase count.
- Every other address reads as zero.

Top module: `dual_wdt`

## Requirements
- R1: After reset the control word at address 0 reads 0 and neither `irq_o` nor `wdt_rst_o` is high.
- R2: The count at address 4 starts at zero and increases by exactly one every clock cycle, whether the watchdog is enabled or not.
- R3: When an expiry occurs while enabled with bit 1 clear, `irq_o` is high for exactly one cycle, in the cycle right after the count's low INTERVAL bits were all ones (so the count's low INTERVAL bits read zero then), and bit 1 of address 0 reads 1.
- R4: Writing 1 to bit 1 of address 0 clears the warning bit; writing 0 there leaves it unchanged. The clear does not restart the count, so the next interrupt follows the previous one by exactly 2^INTERVAL cycles and no reset is issued.
- R5: If bit 1 is still set at the next expiry, `wdt_rst_o` rises exactly 2^INTERVAL cycles after the interrupt and stays high for exactly RST_HOLD consecutive cycles. Afterwards address 0 reads 4: disabled, warning bit clear, reset flag set.
- R6: Writing 1 to bit 2 of address 0 clears the reset flag; writing 0 there leaves it set.
- R7: With ENABLE_ONCE=0, writing 0 to bit 0 of an enabled watchdog clears bits 0 and 1. No interrupt or reset follows at later expiries.
- R8: With ENABLE_ONCE=1, writing 0 to bit 0 of an enabled watchdog is ignored; bit 1 clears still take effect. The enable drops only when a reset sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 3 | Register address (0 control/status, 4 timebase) |
| reg_wdata | input | 3 | Write data for the control/status word |
| reg_rdata | output | CNT_W | Combinational read data for `reg_addr` |
| irq_o | output | 1 | One-cycle interrupt at a first expiry |
| wdt_rst_o | output | 1 | Watchdog reset, high for RST_HOLD cycles |

## Verification
The hardest situation to reach is the second expiry. The bench has to leave the warning bit set for a full interval, or clear it at a known point between expiries, and it has to know exactly where the free-running count stands, because enabling does not restart it.

The stimulus enables the block, then waits on `irq_o` to find the interval boundary. From that edge it measures the distance to the next interrupt or to the reset edge in cycles. The same path is repeated on a second instance built with ENABLE_ONCE=1. On that instance the disable write is attempted while it is locked, and the bench then follows the block through to the reset sequence that releases it.

// File: rtl/dual_wdt_pkg.sv
package dual_wdt_pkg;
  typedef enum logic [1:0] {
    WD_OFF,
    WD_RUN,
    WD_WARN,
    WD_HOLD
  } wd_state_e;

  localparam int unsigned CTL_EN = 0;
  localparam int unsigned CTL_ST = 1;
  localparam int unsigned CTL_RS = 2;

  localparam logic [2:0] ADDR_CTL = 3'h0;
  localparam logic [2:0] ADDR_TB  = 3'h4;

  typedef struct packed {
    logic vld;
    logic en;
    logic clr_st;
    logic clr_rs;
  } ctl_wr_t;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned INTERVAL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  localparam int unsigned SPAN = (INTERVAL > CNT_W) ? CNT_W : INTERVAL;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(1);
  end

  // Last cycle of an interval: the low bits are about to wrap to zero.
  assign tick_o = &cnt_q[SPAN-1:0];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import dual_wdt_pkg::*;
#(
  parameter bit          ENABLE_ONCE = 1'b0,
  parameter int unsigned RST_HOLD    = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_i,
  input  ctl_wr_t wr_i,
  output logic    irq_o,
  output logic    rst_o,
  output logic    en_o,
  output logic    st_o,
  output logic    rs_o
);
  localparam int unsigned HW = (RST_HOLD < 2) ? 1 : $clog2(RST_HOLD);

  wd_state_e state_q, state_d;
  logic [HW-1:0] hold_q, hold_d;
  logic irq_q, irq_d;
  logic rs_q, rs_set;
  logic active, locked, dis_req, clr_req;

  assign active  = (state_q == WD_RUN) || (state_q == WD_WARN);
  assign locked  = ENABLE_ONCE && active;
  assign dis_req = wr_i.vld && !wr_i.en && active && !locked;
  assign clr_req = wr_i.vld && wr_i.clr_st;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    irq_d   = 1'b0;
    rs_set  = 1'b0;
    unique case (state_q)
      WD_OFF: begin
        if (wr_i.vld && wr_i.en) state_d = WD_RUN;
      end
      WD_RUN: begin
        if (dis_req) begin
          state_d = WD_OFF;
        end else if (tick_i) begin
          state_d = WD_WARN;
          irq_d   = 1'b1;
        end
      end
      WD_WARN: begin
        if (dis_req) begin
          state_d = WD_OFF;
        end else if (tick_i) begin
          if (clr_req) begin
            // A clear landing on the expiry counts as in time: warn again.
            irq_d = 1'b1;
          end else begin
            state_d = WD_HOLD;
            hold_d  = HW'(RST_HOLD - 1);
            rs_set  = 1'b1;
          end
        end else if (clr_req) begin
          state_d = WD_RUN;
        end
      end
      WD_HOLD: begin
        if (hold_q == '0) state_d = WD_OFF;
        else              hold_d  = hold_q - HW'(1);
      end
      default: state_d = WD_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WD_OFF;
      hold_q  <= '0;
      irq_q   <= 1'b0;
      rs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      irq_q   <= irq_d;
      if (rs_set)                       rs_q <= 1'b1;
      else if (wr_i.vld && wr_i.clr_rs) rs_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
  assign rst_o = (state_q == WD_HOLD);
  assign en_o  = (state_q != WD_OFF);
  assign st_o  = (state_q == WD_WARN) || (state_q == WD_HOLD);
  assign rs_o  = rs_q;
endmodule

// File: rtl/wdt_rdmux.sv
module wdt_rdmux
  import dual_wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [2:0]       addr_i,
  input  logic             en_i,
  input  logic             st_i,
  input  logic             rs_i,
  input  logic [CNT_W-1:0] tb_i,
  output logic [CNT_W-1:0] rdata_o
);
  logic [CNT_W-1:0] ctl_word;

  always_comb begin
    ctl_word         = '0;
    ctl_word[CTL_EN] = en_i;
    ctl_word[CTL_ST] = st_i;
    ctl_word[CTL_RS] = rs_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTL: rdata_o = ctl_word;
      ADDR_TB:  rdata_o = tb_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_wdt.sv
module dual_wdt
  import dual_wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned INTERVAL    = 8,
  parameter bit          ENABLE_ONCE = 1'b0,
  parameter int unsigned RST_HOLD    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [2:0]       reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq_o,
  output logic             wdt_rst_o
);
  logic [CNT_W-1:0] tb_cnt;
  logic             tick;
  logic             en_bit, st_bit, rs_bit;
  ctl_wr_t          ctl_wr;

  always_comb begin
    ctl_wr.vld    = reg_wr && (reg_addr == ADDR_CTL);
    ctl_wr.en     = reg_wdata[CTL_EN];
    ctl_wr.clr_st = reg_wdata[CTL_ST];
    ctl_wr.clr_rs = reg_wdata[CTL_RS];
  end

  wdt_timebase #(.CNT_W(CNT_W), .INTERVAL(INTERVAL)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_o  (tb_cnt),
    .tick_o (tick)
  );

  wdt_ctrl #(.ENABLE_ONCE(ENABLE_ONCE), .RST_HOLD(RST_HOLD)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .wr_i   (ctl_wr),
    .irq_o  (irq_o),
    .rst_o  (wdt_rst_o),
    .en_o   (en_bit),
    .st_o   (st_bit),
    .rs_o   (rs_bit)
  );

  wdt_rdmux #(.CNT_W(CNT_W)) u_rd (
    .addr_i  (reg_addr),
    .en_i    (en_bit),
    .st_i    (st_bit),
    .rs_i    (rs_bit),
    .tb_i    (tb_cnt),
    .rdata_o (reg_rdata)
  );
endmodule

// File: rtl/dual_wdt_chk.sv
module dual_wdt_chk #(
  parameter int unsigned CNT_W       = 32,
  parameter bit          ENABLE_ONCE = 1'b0,
  parameter int unsigned RST_HOLD    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] tb_cnt,
  input logic             irq_o,
  input logic             wdt_rst_o,
  input logic             en_bit,
  input logic             st_bit
);
  int unsigned run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_q <= 0;
    else if (wdt_rst_o) run_q <= run_q + 1;
    else                run_q <= 0;
  end

  // R2
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tb_cnt == $past(tb_cnt) + CNT_W'(1));

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R3
  irq_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(tick) && st_bit);

  // R5
  rst_after_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(st_bit) && $past(tick));

  // R5
  rst_max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> run_q < RST_HOLD);

  // R5
  rst_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_o) |-> run_q == RST_HOLD);

  // R7
  st_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_bit |-> en_bit);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ENABLE_ONCE && $fell(en_bit)) |-> $past(wdt_rst_o));
endmodule

bind dual_wdt dual_wdt_chk #(
  .CNT_W(CNT_W), .ENABLE_ONCE(ENABLE_ONCE), .RST_HOLD(RST_HOLD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .tb_cnt    (tb_cnt),
  .irq_o     (irq_o),
  .wdt_rst_o (wdt_rst_o),
  .en_bit    (en_bit),
  .st_bit    (st_bit)
);

// File: tb/dual_wdt_bench.sv
module dual_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 8;
  localparam int PERIOD     = 1 << INTERVAL;
  localparam int HOLD       = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [2:0]  addr_a = '0, addr_b = '0;
  logic [2:0]  wdata_a = '0, wdata_b = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b, rst_a, rst_b;

  dual_wdt #(.INTERVAL(INTERVAL), .ENABLE_ONCE(1'b0), .RST_HOLD(HOLD)) u_dual_wdt (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_addr(addr_a),
    .reg_wdata(wdata_a), .reg_rdata(rdata_a), .irq_o(irq_a), .wdt_rst_o(rst_a)
  );

  dual_wdt #(.INTERVAL(INTERVAL), .ENABLE_ONCE(1'b1), .RST_HOLD(HOLD)) u_dual_wdt_lk (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_addr(addr_b),
    .reg_wdata(wdata_b), .reg_rdata(rdata_b), .irq_o(irq_b), .wdt_rst_o(rst_b)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int irq_hits_a = 0;
  int rst_hits_a = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (irq_a) irq_hits_a <= irq_hits_a + 1;
    if (rst_a) rst_hits_a <= rst_hits_a + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [2:0] ad, input logic [2:0] d);
    @(negedge clk);
    if (sel) begin wr_b = 1'b1; addr_b = ad; wdata_b = d; end
    else     begin wr_a = 1'b1; addr_a = ad; wdata_a = d; end
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0; addr_a = '0; addr_b = '0;
  endtask

  task automatic rd(input bit sel, input logic [2:0] ad, output logic [31:0] d);
    if (sel) addr_b = ad; else addr_a = ad;
    #1;
    d = sel ? rdata_b : rdata_a;
    addr_a = '0; addr_b = '0;
  endtask

  // which: 0 waits for the interrupt, 1 for the watchdog reset
  task automatic wait_for(input bit sel, input bit which, input string req, output int t);
    bit found = 1'b0;
    t = 0;
    for (int i = 0; i < 4 * PERIOD; i++) begin
      @(negedge clk);
      if ((which ? (sel ? rst_b : rst_a) : (sel ? irq_b : irq_a)) === 1'b1) begin
        found = 1'b1;
        t = cyc;
        break;
      end
    end
    chk(req, 32'(found), 32'd1);
  endtask

  task automatic t_reset_state();
    logic [31:0] d, d2;
    rd(0, 3'h0, d); chk("R1 ctl after reset", d, 32'h0);
    rd(1, 3'h0, d); chk("R1 ctl after reset (locked build)", d, 32'h0);
    chk("R1 outputs idle", {28'h0, irq_a, rst_a, irq_b, rst_b}, 32'h0);
    rd(0, 3'h4, d);
    repeat (10) @(negedge clk);
    rd(0, 3'h4, d2);
    chk("R2 timebase advance while disabled", d2 - d, 32'd10);
  endtask

  task automatic t_clear_in_time();
    logic [31:0] d;
    int t1, t2, r0;
    wr(0, 3'h0, 3'b001);
    wait_for(0, 0, "R3 first interrupt", t1);
    r0 = rst_hits_a;
    rd(0, 3'h4, d); chk("R3 count low bits zero at interrupt", d & 32'hFF, 32'h0);
    rd(0, 3'h0, d); chk("R3 warning bit set", d, 32'h3);
    @(negedge clk); chk("R3 interrupt one cycle", 32'(irq_a), 32'd0);
    wr(0, 3'h0, 3'b001);
    rd(0, 3'h0, d); chk("R4 writing zero keeps warning", d, 32'h3);
    wr(0, 3'h0, 3'b011);
    rd(0, 3'h0, d); chk("R4 write one clears warning", d, 32'h1);
    wait_for(0, 0, "R4 next interrupt", t2);
    chk("R4 interval not restarted", 32'(t2 - t1), 32'(PERIOD));
    chk("R4 no reset after clear", 32'(rst_hits_a - r0), 32'd0);
    wr(0, 3'h0, 3'b000);
  endtask

  task automatic t_skip_clear();
    logic [31:0] d;
    int t1, t2, n;
    wr(0, 3'h0, 3'b001);
    wait_for(0, 0, "R5 first interrupt", t1);
    wait_for(0, 1, "R5 reset asserted", t2);
    chk("R5 reset one interval after interrupt", 32'(t2 - t1), 32'(PERIOD));
    n = 1;
    for (int i = 0; i < 4 * HOLD; i++) begin
      @(negedge clk);
      if (!rst_a) break;
      n++;
    end
    chk("R5 reset length", 32'(n), 32'(HOLD));
    rd(0, 3'h0, d); chk("R5 state after reset", d, 32'h4);
    wr(0, 3'h0, 3'b000);
    rd(0, 3'h0, d); chk("R6 writing zero keeps flag", d, 32'h4);
    wr(0, 3'h0, 3'b100);
    rd(0, 3'h0, d); chk("R6 write one clears flag", d, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    int t1, i0, r0;
    wr(0, 3'h0, 3'b001);
    wait_for(0, 0, "R7 interrupt before disable", t1);
    rd(0, 3'h0, d); chk("R7 warning before disable", d, 32'h3);
    wr(0, 3'h0, 3'b000);
    rd(0, 3'h0, d); chk("R7 disable clears enable and warning", d, 32'h0);
    i0 = irq_hits_a; r0 = rst_hits_a;
    repeat (3 * PERIOD) @(negedge clk);
    chk("R7 no interrupt while disabled", 32'(irq_hits_a - i0), 32'd0);
    chk("R7 no reset while disabled", 32'(rst_hits_a - r0), 32'd0);
  endtask

  task automatic t_locked();
    logic [31:0] d;
    int t1;
    wr(1, 3'h0, 3'b001);
    wr(1, 3'h0, 3'b000);
    rd(1, 3'h0, d); chk("R8 disable ignored when locked", d, 32'h1);
    wait_for(1, 0, "R8 interrupt while locked", t1);
    wr(1, 3'h0, 3'b010);
    rd(1, 3'h0, d); chk("R8 clear honoured, enable kept", d, 32'h1);
    wait_for(1, 0, "R8 second interrupt", t1);
    wr(1, 3'h0, 3'b000);
    rd(1, 3'h0, d); chk("R8 disable ignored in warning", d, 32'h3);
    wait_for(1, 1, "R8 reset reached", t1);
    while (rst_b) @(negedge clk);
    rd(1, 3'h0, d); chk("R8 enable dropped after reset", d, 32'h4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_clear_in_time();
    t_skip_clear();
    t_disable();
    t_locked();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end
endmodule